// File: doc/BRIEF.md
# Link Control Symbol Codec

This block sits between a packet link layer and a full-duplex word-wide link. On the outgoing side it turns a 16-bit control field into a 32-bit control symbol: the field in the upper half and its bitwise inverse in the lower half. It merges these symbols into the stream of packet data words, and a per-word flag tells the far end which words are symbols. A symbol offered in the same cycle as a data word goes out first. The data source is held off through a ready signal, so a symbol can land between any two words of a packet already in flight.

On the incoming side the block uses the same flag to split the word stream. Data words are passed on. Symbol words are checked by comparing the lower half against the inverse of the upper half. A word that passes is decoded into its kind, acknowledge ID and parameter fields. A word that fails is dropped and a one-cycle error pulse is raised, and the link layer uses that pulse to ask its neighbour to resend. The payload layout is: bits 15..13 kind (0 ack, 1 resend request, 2 idle/wait, 3 end of packet, 4 buffer status query, 5 buffer status answer), bits 12..8 acknowledge ID, bits 7..0 parameter.

Both directions are single-stage registered state machines. The transmit machine has states TX_QUIET, TX_DATA and TX_SYM. From any state it moves to TX_SYM when a symbol is offered, otherwise to TX_DATA when data is offered, otherwise to TX_QUIET. The receive machine has states RX_QUIET, RX_DATA, RX_SYM and RX_ERR. From any state it moves to RX_ERR on a flagged word that fails the check, to RX_SYM on a flagged word that passes, to RX_DATA on an unflagged word, and to RX_QUIET when no word arrives.

Top module: `lcs_codec`

## Requirements
- R1: After reset, tx_valid_o, rx_data_valid_o, rx_sym_valid_o and rx_sym_err_o are 0, and pkt_ready_o is 1 while no symbol is offered.
- R2: A symbol offered with field F appears one cycle later as tx_word_o = {F, ~F} with tx_is_sym_o = 1 and tx_valid_o = 1.
- R3: A data word accepted (pkt_valid_i and pkt_ready_o both 1) appears unchanged one cycle later with tx_is_sym_o = 0.
- R4: In any cycle with sym_valid_i = 1, pkt_ready_o is 0 and only the symbol is sent. The data word offered that cycle is not consumed and goes out once it is offered again without a symbol.
- R5: Symbols inserted between data words of one packet leave the order and content of the data words unchanged.
- R6: A flagged received word whose bits 15..0 equal the inverse of bits 31..16 raises rx_sym_valid_o one cycle later with type = bits 31..29, ackID = bits 28..24, parameter = bits 23..16. An idle/wait kind (2) is reported like any other kind.
- R7: A flagged received word failing that check raises rx_sym_err_o for exactly one cycle, one cycle later, with rx_sym_valid_o and rx_data_valid_o both 0. The all-zero word is such a failure.
- R8: An unflagged received word appears one cycle later on rx_data_o with rx_data_valid_o = 1 and rx_sym_valid_o = 0.
- R9: A cycle with no received word (rx_valid_i = 0) gives rx_data_valid_o, rx_sym_valid_o and rx_sym_err_o all 0 one cycle later, and a cycle with nothing to send gives tx_valid_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid_i | input | 1 | Control field offered for sending |
| sym_field_i | input | 16 | Control field to encode |
| pkt_valid_i | input | 1 | Packet data word offered |
| pkt_data_i | input | 32 | Packet data word |
| pkt_ready_o | output | 1 | Data word accepted this cycle |
| tx_valid_o | output | 1 | Outgoing word present |
| tx_is_sym_o | output | 1 | Outgoing word is a control symbol |
| tx_word_o | output | 32 | Outgoing link word |
| rx_valid_i | input | 1 | Incoming word present |
| rx_is_sym_i | input | 1 | Incoming word flagged as control symbol |
| rx_word_i | input | 32 | Incoming link word |
| rx_data_valid_o | output | 1 | Received data word present |
| rx_data_o | output | 32 | Received data word |
| rx_sym_valid_o | output | 1 | Checked symbol present |
| rx_sym_type_o | output | 3 | Symbol kind |
| rx_sym_ackid_o | output | 5 | Symbol acknowledge ID |
| rx_sym_param_o | output | 8 | Symbol parameter |
| rx_sym_err_o | output | 1 | One-cycle symbol check failure pulse |

## Verification
The hardest case is a symbol arriving in the same cycle as a data word in the middle of a packet. The held word must then go out in the next slot, neither lost nor sent twice. The driver makes this happen by offering both at once while a packet is streaming. It checks pkt_ready_o in that cycle and offers the same word again afterwards, and the scoreboard queue checks that the data order is unchanged. On receive, single-bit corruptions and the all-zero word reach the error path, mixed in with good symbols and data.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
    localparam int FIELD_W = 16;
    localparam int TYPE_W  = 3;
    localparam int ACK_W   = 5;
    localparam int PARAM_W = FIELD_W - TYPE_W - ACK_W;
    localparam int WORD_W  = 2 * FIELD_W;

    typedef enum logic [1:0] {TX_QUIET, TX_DATA, TX_SYM} tx_state_e;
    typedef enum logic [1:0] {RX_QUIET, RX_DATA, RX_SYM, RX_ERR} rx_state_e;

    function automatic logic [WORD_W-1:0] seal(input logic [FIELD_W-1:0] f);
        return {f, ~f};
    endfunction

    function automatic logic intact(input logic [WORD_W-1:0] w);
        return w[FIELD_W-1:0] == ~w[WORD_W-1:FIELD_W];
    endfunction
endpackage

// File: rtl/lcs_tx.sv
module lcs_tx
    import lcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sym_valid_i,
    input  logic [FIELD_W-1:0] sym_field_i,
    input  logic               pkt_valid_i,
    input  logic [WORD_W-1:0]  pkt_data_i,
    output logic               pkt_ready_o,
    output logic               tx_valid_o,
    output logic               tx_is_sym_o,
    output logic [WORD_W-1:0]  tx_word_o
);
    tx_state_e         state_q, state_d;
    logic [WORD_W-1:0] word_q, word_d;

    // Symbols win; data is held off while a symbol is offered.
    assign pkt_ready_o = !sym_valid_i;

    always_comb begin
        if (sym_valid_i) begin
            state_d = TX_SYM;
            word_d  = seal(sym_field_i);
        end else if (pkt_valid_i) begin
            state_d = TX_DATA;
            word_d  = pkt_data_i;
        end else begin
            state_d = TX_QUIET;
            word_d  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_QUIET;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
        end
    end

    always_comb begin
        tx_word_o = word_q;
        unique case (state_q)
            TX_QUIET: begin tx_valid_o = 1'b0; tx_is_sym_o = 1'b0; end
            TX_DATA:  begin tx_valid_o = 1'b1; tx_is_sym_o = 1'b0; end
            TX_SYM:   begin tx_valid_o = 1'b1; tx_is_sym_o = 1'b1; end
            default:  begin tx_valid_o = 1'b0; tx_is_sym_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/lcs_rx.sv
module lcs_rx
    import lcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid_i,
    input  logic               rx_is_sym_i,
    input  logic [WORD_W-1:0]  rx_word_i,
    output logic               rx_data_valid_o,
    output logic [WORD_W-1:0]  rx_data_o,
    output logic               rx_sym_valid_o,
    output logic [TYPE_W-1:0]  rx_sym_type_o,
    output logic [ACK_W-1:0]   rx_sym_ackid_o,
    output logic [PARAM_W-1:0] rx_sym_param_o,
    output logic               rx_sym_err_o
);
    rx_state_e         state_q, state_d;
    logic [WORD_W-1:0] word_q, word_d;

    always_comb begin
        word_d = rx_word_i;
        if (!rx_valid_i) begin
            state_d = RX_QUIET;
            word_d  = '0;
        end else if (!rx_is_sym_i) begin
            state_d = RX_DATA;
        end else if (intact(rx_word_i)) begin
            state_d = RX_SYM;
        end else begin
            state_d = RX_ERR;
            word_d  = '0;   // bad symbol is discarded
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_QUIET;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
        end
    end

    always_comb begin
        rx_data_o      = word_q;
        rx_sym_type_o  = word_q[WORD_W-1 -: TYPE_W];
        rx_sym_ackid_o = word_q[WORD_W-TYPE_W-1 -: ACK_W];
        rx_sym_param_o = word_q[FIELD_W +: PARAM_W];
        unique case (state_q)
            RX_QUIET: begin rx_data_valid_o = 1'b0; rx_sym_valid_o = 1'b0; rx_sym_err_o = 1'b0; end
            RX_DATA:  begin rx_data_valid_o = 1'b1; rx_sym_valid_o = 1'b0; rx_sym_err_o = 1'b0; end
            RX_SYM:   begin rx_data_valid_o = 1'b0; rx_sym_valid_o = 1'b1; rx_sym_err_o = 1'b0; end
            RX_ERR:   begin rx_data_valid_o = 1'b0; rx_sym_valid_o = 1'b0; rx_sym_err_o = 1'b1; end
            default:  begin rx_data_valid_o = 1'b0; rx_sym_valid_o = 1'b0; rx_sym_err_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/lcs_codec.sv
module lcs_codec
    import lcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sym_valid_i,
    input  logic [FIELD_W-1:0] sym_field_i,
    input  logic               pkt_valid_i,
    input  logic [WORD_W-1:0]  pkt_data_i,
    output logic               pkt_ready_o,
    output logic               tx_valid_o,
    output logic               tx_is_sym_o,
    output logic [WORD_W-1:0]  tx_word_o,
    input  logic               rx_valid_i,
    input  logic               rx_is_sym_i,
    input  logic [WORD_W-1:0]  rx_word_i,
    output logic               rx_data_valid_o,
    output logic [WORD_W-1:0]  rx_data_o,
    output logic               rx_sym_valid_o,
    output logic [TYPE_W-1:0]  rx_sym_type_o,
    output logic [ACK_W-1:0]   rx_sym_ackid_o,
    output logic [PARAM_W-1:0] rx_sym_param_o,
    output logic               rx_sym_err_o
);
    lcs_tx u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_valid_i (sym_valid_i),
        .sym_field_i (sym_field_i),
        .pkt_valid_i (pkt_valid_i),
        .pkt_data_i  (pkt_data_i),
        .pkt_ready_o (pkt_ready_o),
        .tx_valid_o  (tx_valid_o),
        .tx_is_sym_o (tx_is_sym_o),
        .tx_word_o   (tx_word_o)
    );

    lcs_rx u_rx (
        .clk             (clk),
        .rst_n           (rst_n),
        .rx_valid_i      (rx_valid_i),
        .rx_is_sym_i     (rx_is_sym_i),
        .rx_word_i       (rx_word_i),
        .rx_data_valid_o (rx_data_valid_o),
        .rx_data_o       (rx_data_o),
        .rx_sym_valid_o  (rx_sym_valid_o),
        .rx_sym_type_o   (rx_sym_type_o),
        .rx_sym_ackid_o  (rx_sym_ackid_o),
        .rx_sym_param_o  (rx_sym_param_o),
        .rx_sym_err_o    (rx_sym_err_o)
    );
endmodule

// File: rtl/lcs_codec_chk.sv
module lcs_codec_chk
    import lcs_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               sym_valid_i,
    input logic [FIELD_W-1:0] sym_field_i,
    input logic               pkt_valid_i,
    input logic [WORD_W-1:0]  pkt_data_i,
    input logic               pkt_ready_o,
    input logic               tx_valid_o,
    input logic               tx_is_sym_o,
    input logic [WORD_W-1:0]  tx_word_o,
    input logic               rx_valid_i,
    input logic               rx_is_sym_i,
    input logic [WORD_W-1:0]  rx_word_i,
    input logic               rx_data_valid_o,
    input logic [WORD_W-1:0]  rx_data_o,
    input logic               rx_sym_valid_o,
    input logic [TYPE_W-1:0]  rx_sym_type_o,
    input logic [ACK_W-1:0]   rx_sym_ackid_o,
    input logic [PARAM_W-1:0] rx_sym_param_o,
    input logic               rx_sym_err_o
);
    assert_sym_encode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_i |=> tx_valid_o && tx_is_sym_o &&
                        tx_word_o == {$past(sym_field_i), ~$past(sym_field_i)});

    assert_data_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid_i && pkt_ready_o) |=> tx_valid_o && !tx_is_sym_o &&
                                         tx_word_o == $past(pkt_data_i));

    assert_sym_blocks_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_i |-> !pkt_ready_o);

    assert_good_sym_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && rx_is_sym_i && rx_word_i[15:0] == ~rx_word_i[31:16])
        |=> rx_sym_valid_o && rx_sym_type_o == $past(rx_word_i[31:29]) &&
            rx_sym_ackid_o == $past(rx_word_i[28:24]));

    assert_bad_sym_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && rx_is_sym_i && rx_word_i[15:0] != ~rx_word_i[31:16])
        |=> rx_sym_err_o && !rx_sym_valid_o && !rx_data_valid_o);

    assert_data_recv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !rx_is_sym_i) |=> rx_data_valid_o && rx_data_o == $past(rx_word_i));

    assert_rx_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_i |=> !rx_data_valid_o && !rx_sym_valid_o && !rx_sym_err_o);

    assert_rx_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_data_valid_o, rx_sym_valid_o, rx_sym_err_o}));
endmodule

bind lcs_codec lcs_codec_chk u_chk (.*);

// File: tb/tb_lcs_codec.sv
module tb_lcs_codec;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid_i = 1'b0;
    logic [15:0] sym_field_i = '0;
    logic        pkt_valid_i = 1'b0;
    logic [31:0] pkt_data_i = '0;
    logic        pkt_ready_o, tx_valid_o, tx_is_sym_o;
    logic [31:0] tx_word_o;
    logic        rx_valid_i = 1'b0;
    logic        rx_is_sym_i = 1'b0;
    logic [31:0] rx_word_i = '0;
    logic        rx_data_valid_o, rx_sym_valid_o, rx_sym_err_o;
    logic [31:0] rx_data_o;
    logic [2:0]  rx_sym_type_o;
    logic [4:0]  rx_sym_ackid_o;
    logic [7:0]  rx_sym_param_o;

    int checks = 0;
    int failures = 0;
    logic [32:0] tx_q[$];   // {is_sym, word}
    logic [33:0] rx_q[$];   // {kind(0 data,1 sym,2 err), word}

    always #(CLK_PERIOD/2) clk = ~clk;

    lcs_codec dut (.*);

    function automatic void check(bit ok, string req, logic [33:0] act, logic [33:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endfunction

    // transmit scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && tx_valid_o) begin
            if (tx_q.size() == 0)
                check(0, "R9 unexpected tx word", {1'b0, tx_is_sym_o, tx_word_o}, '0);
            else begin
                logic [32:0] e;
                e = tx_q.pop_front();
                check({tx_is_sym_o, tx_word_o} == e, e[32] ? "R2 symbol word" : "R3/R5 data word",
                      {1'b0, tx_is_sym_o, tx_word_o}, {1'b0, e});
            end
        end
    end

    // receive scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (rx_data_valid_o || rx_sym_valid_o || rx_sym_err_o)) begin
            logic [1:0] k;
            k = rx_data_valid_o ? 2'd0 : (rx_sym_valid_o ? 2'd1 : 2'd2);
            if (rx_q.size() == 0)
                check(0, "R9 unexpected rx output", {k, rx_data_o}, '0);
            else begin
                logic [33:0] e;
                e = rx_q.pop_front();
                unique case (e[33:32])
                    2'd0: check(rx_data_valid_o && !rx_sym_valid_o && rx_data_o == e[31:0],
                                "R8 data receive", {k, rx_data_o}, e);
                    2'd1: check(rx_sym_valid_o && !rx_sym_err_o && rx_sym_type_o == e[31:29] &&
                                rx_sym_ackid_o == e[28:24] && rx_sym_param_o == e[23:16],
                                "R6 symbol decode",
                                {k, rx_sym_type_o, rx_sym_ackid_o, rx_sym_param_o, 16'h0},
                                {e[33:32], e[31:16], 16'h0});
                    default: check(rx_sym_err_o && !rx_sym_valid_o && !rx_data_valid_o,
                                   "R7 symbol error", {k, 32'h0}, {e[33:32], 32'h0});
                endcase
            end
        end
    end

    task automatic tx_step(bit sv, logic [15:0] f, bit pv, logic [31:0] d);
        @(negedge clk);
        sym_valid_i = sv; sym_field_i = f; pkt_valid_i = pv; pkt_data_i = d;
        #1;
        check(pkt_ready_o == !sv, "R4 ready while symbol offered", {33'h0, pkt_ready_o}, {33'h0, !sv});
        if (sv) tx_q.push_back({1'b1, f, ~f});
        else if (pv) tx_q.push_back({1'b0, d});
    endtask

    task automatic rx_step(bit v, bit s, logic [31:0] w);
        @(negedge clk);
        rx_valid_i = v; rx_is_sym_i = s; rx_word_i = w;
        if (v) begin
            if (!s) rx_q.push_back({2'd0, w});
            else if (w[15:0] == ~w[31:16]) rx_q.push_back({2'd1, w});
            else rx_q.push_back({2'd2, w});
        end
    endtask

    function automatic logic [31:0] sym_word(logic [2:0] t, logic [4:0] a, logic [7:0] p);
        return {t, a, p, ~{t, a, p}};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!tx_valid_o && !rx_data_valid_o && !rx_sym_valid_o && !rx_sym_err_o,
              "R1 outputs after reset",
              {30'h0, tx_valid_o, rx_data_valid_o, rx_sym_valid_o, rx_sym_err_o}, '0);
        check(pkt_ready_o, "R1 ready after reset", {33'h0, pkt_ready_o}, 34'h1);

        // transmit: standalone symbol, packet with mid-packet insertion
        tx_step(1, {3'd0, 5'd7, 8'h00}, 0, '0);          // R2 ack alone
        tx_step(0, '0, 1, 32'hA000_0001);                // R3
        tx_step(0, '0, 1, 32'hA000_0002);
        tx_step(1, {3'd2, 5'd3, 8'h00}, 1, 32'hA000_0003); // R4/R5 collision, idle symbol
        tx_step(1, {3'd1, 5'd4, 8'h00}, 1, 32'hA000_0003); // back-to-back symbols
        tx_step(0, '0, 1, 32'hA000_0003);                // held word re-offered
        tx_step(0, '0, 1, 32'hFFFF_FFFF);
        tx_step(1, {3'd3, 5'd31, 8'hFF}, 0, '0);         // end of packet
        tx_step(1, 16'h0000, 0, '0);                     // all-zero field
        tx_step(0, '0, 0, '0);
        @(negedge clk);
        #1;
        check(!tx_valid_o, "R9 tx quiet", {33'h0, tx_valid_o}, '0);

        // receive
        rx_step(1, 0, 32'h1234_5678);                    // R8
        rx_step(1, 1, sym_word(3'd2, 5'd9, 8'h00));      // R6 idle mid packet
        rx_step(1, 0, 32'h9ABC_DEF0);
        rx_step(1, 1, sym_word(3'd5, 5'd17, 8'd4));      // buffer answer
        rx_step(1, 1, sym_word(3'd0, 5'd1, 8'd0) ^ 32'h0000_0100); // R7 one-bit flip
        rx_step(1, 1, 32'h0000_0000);                    // R7 all-zero
        rx_step(1, 1, 32'h0000_FFFF);                    // R6 all-zero payload good
        rx_step(1, 1, sym_word(3'd4, 5'd31, 8'hFF) ^ 32'h8000_0000); // R7 top bit flip
        rx_step(1, 0, 32'h0000_0000);                    // R8 zero data, not a symbol
        rx_step(0, 0, '0);
        @(negedge clk);
        #1;
        check(!rx_data_valid_o && !rx_sym_valid_o && !rx_sym_err_o, "R9 rx quiet",
              {31'h0, rx_data_valid_o, rx_sym_valid_o, rx_sym_err_o}, '0);
        // R7 error pulse lasts one cycle
        rx_step(1, 1, 32'hDEAD_BEEF);
        rx_step(0, 0, '0);
        @(negedge clk);
        #1;
        check(!rx_sym_err_o, "R7 error pulse single cycle", {33'h0, rx_sym_err_o}, '0);

        repeat (3) @(negedge clk);
        check(tx_q.size() == 0, "R5 all tx words delivered", tx_q.size(), '0);
        check(rx_q.size() == 0, "R6 all rx results delivered", rx_q.size(), '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule